// File: doc/BRIEF.md
# Transmit Start Delay Timer

This block holds back the start of a transmission until a programmed delay has passed after a chosen protocol event. It lets a reader answer a tag inside a fixed time slot. Two 8-bit host registers hold the setup. One holds a 2-bit trigger select and the upper part of a 14-bit countdown preset. The other holds the lower eight preset bits. An external clock enable, `tick`, arrives once every 590 ns and sets the time base. A preset of N therefore gives a delay of N × 590 ns, from 590 ns up to about 9.7 ms.

When the selected event arrives, the counter loads the preset and counts ticks down. On expiry it raises `tx_start` for one system clock. When the timer is off, either because the select is 00 or because the preset is zero, a transmit command passes straight through to `tx_start` one cycle later. A host write to either register cancels a running countdown. All pins are plain control strobes: no stream data crosses this block, so no valid/ready handshake is involved.

Top module: `tx_start_timer`

## Requirements
- R1: After reset `tx_start` and `busy` are low and both setup registers are zero, so the timer is off.
- R2: A write with `wr_addr`=0 loads the high register: bits 7:6 are the trigger select and bits 5:0 are preset bits 13:8. A write with `wr_addr`=1 loads preset bits 7:0. A write takes effect at the clock edge on which `wr_en` is sampled.
- R3: Trigger select 2'b01 arms on `ev_rx_start`, 2'b10 on `ev_rx_end` and 2'b11 on `ev_tx_end`. The two events that are not selected have no effect: `busy` stays low.
- R4: With select 2'b00 or a zero preset, events never raise `busy`, and `tx_cmd` raises `tx_start` in the next cycle.
- R5: With a nonzero select and a nonzero preset, `tx_cmd` has no effect on `tx_start` or `busy`.
- R6: A matching event loads the preset, and `busy` is high from the next cycle. A tick in the trigger cycle is not counted. `tx_start` rises, and `busy` falls, in the cycle after the preset-th tick that follows the trigger cycle.
- R7: A matching event during a countdown restarts it from the full preset and issues no pulse for the earlier run.
- R8: A register write during a countdown drops `busy` in the next cycle and no pulse follows. An event in the same cycle as a write is ignored.
- R9: Each expiry gives exactly one `tx_start` pulse, one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable every 590 ns (time base) |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 1 | 0 = select/high preset register, 1 = low preset register |
| wr_data | input | 8 | Host write data |
| ev_rx_start | input | 1 | Receive-start event strobe |
| ev_rx_end | input | 1 | Receive-end event strobe |
| ev_tx_end | input | 1 | Transmit-end event strobe |
| tx_cmd | input | 1 | Transmit command from host (used when timer is off) |
| tx_start | output | 1 | One-cycle transmit start pulse |
| busy | output | 1 | Countdown in progress |

## Verification
The properties assume only two things: the event, command and write strobes are synchronous to `clk`, and `tick` is a plain level sampled each cycle, with no fixed spacing. They do not assume events arrive one at a time or apart from writes. The stimulus therefore fires events, commands, ticks and writes together in the same cycle quite often. Written presets are kept mostly small, so that many countdowns reach expiry within the run. Directed sequences cover a zero preset, a retrigger, an abort by write, and the upper preset byte.

// File: rtl/tst_pkg.sv
package tst_pkg;
  typedef enum logic [1:0] {
    TRIG_OFF      = 2'b00,
    TRIG_RX_START = 2'b01,
    TRIG_RX_END   = 2'b10,
    TRIG_TX_END   = 2'b11
  } trig_sel_e;
endpackage

// File: rtl/tst_cfg_regs.sv
module tst_cfg_regs
  import tst_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PRESET_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output trig_sel_e           sel,
  output logic [PRESET_W-1:0] preset
);
  localparam int HI_W = PRESET_W - DATA_W;

  logic [DATA_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_en) begin
      if (wr_addr) lo_q <= wr_data;
      else         hi_q <= wr_data;
    end
  end

  assign sel    = trig_sel_e'(hi_q[DATA_W-1 -: 2]);
  assign preset = {hi_q[HI_W-1:0], lo_q};
endmodule

// File: rtl/tst_trig_sel.sv
module tst_trig_sel
  import tst_pkg::*;
(
  input  trig_sel_e sel,
  input  logic      ev_rx_start,
  input  logic      ev_rx_end,
  input  logic      ev_tx_end,
  output logic      hit
);
  always_comb begin
    unique case (sel)
      TRIG_RX_START: hit = ev_rx_start;
      TRIG_RX_END:   hit = ev_rx_end;
      TRIG_TX_END:   hit = ev_tx_end;
      default:       hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tst_countdown.sv
module tst_countdown #(
  parameter int PRESET_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                load,
  input  logic                abort,
  input  logic [PRESET_W-1:0] preset,
  output logic                busy,
  output logic                expire
);
  localparam logic [PRESET_W-1:0] ONE = PRESET_W'(1);

  logic [PRESET_W-1:0] cnt_q;
  logic                run_q;

  assign expire = run_q && tick && (cnt_q == ONE) && !load && !abort;
  assign busy   = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (abort) begin
      run_q <= 1'b0;
    end else if (load) begin
      run_q <= 1'b1;
      cnt_q <= preset;
    end else if (run_q && tick) begin
      if (cnt_q == ONE) run_q <= 1'b0;
      else              cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/tx_start_timer.sv
module tx_start_timer
  import tst_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PRESET_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ev_rx_start,
  input  logic              ev_rx_end,
  input  logic              ev_tx_end,
  input  logic              tx_cmd,
  output logic              tx_start,
  output logic              busy
);
  trig_sel_e           trig_sel;
  logic [PRESET_W-1:0] preset;
  logic                trig_hit;
  logic                direct;
  logic                load;
  logic                expire;

  tst_cfg_regs #(.DATA_W(DATA_W), .PRESET_W(PRESET_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sel(trig_sel), .preset(preset)
  );

  tst_trig_sel u_trig (
    .sel(trig_sel), .ev_rx_start(ev_rx_start), .ev_rx_end(ev_rx_end),
    .ev_tx_end(ev_tx_end), .hit(trig_hit)
  );

  assign direct = (trig_sel == TRIG_OFF) || (preset == '0);
  assign load   = trig_hit && !direct && !wr_en;

  tst_countdown #(.PRESET_W(PRESET_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .abort(wr_en),
    .preset(preset), .busy(busy), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_start <= 1'b0;
    else        tx_start <= expire || (direct && tx_cmd);
  end
endmodule

// File: rtl/tst_checker.sv
module tst_checker #(
  parameter int PRESET_W = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [1:0]          sel,
  input logic [PRESET_W-1:0] preset,
  input logic                hit,
  input logic                busy,
  input logic                tx_start
);
  // R4: timer off means no countdown
  p_off_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00 || preset == '0) |-> !busy);

  // R6: matching event with valid setup arms the counter
  p_trigger_arms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sel != 2'b00 && preset != '0 && !wr_en) |=> busy);

  // R8: a write cancels any countdown
  p_write_aborts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !busy);

  // R9: countdown ending without a write must produce the pulse
  p_expiry_pulses_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(wr_en)) |-> tx_start);

  // R5: while counting, a pulse only accompanies the end of the run
  p_no_pulse_mid_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !tx_start);
endmodule

bind tx_start_timer tst_checker #(.PRESET_W(PRESET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(trig_sel),
  .preset(preset), .hit(trig_hit), .busy(busy), .tx_start(tx_start)
);

// File: tb/tx_start_timer_test.sv
module tx_start_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic ev_rx_start = 1'b0, ev_rx_end = 1'b0, ev_tx_end = 1'b0, tx_cmd = 1'b0;
  logic tx_start, busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  m_hi = 8'h00, m_lo = 8'h00;
  logic [13:0] m_cnt = '0;
  logic        m_run = 1'b0, m_pulse = 1'b0;

  always #10 clk = ~clk;

  tx_start_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ev_rx_start(ev_rx_start), .ev_rx_end(ev_rx_end),
    .ev_tx_end(ev_tx_end), .tx_cmd(tx_cmd), .tx_start(tx_start), .busy(busy)
  );

  function automatic logic [13:0] preset_of(logic [7:0] hi, logic [7:0] lo);
    return {hi[5:0], lo};
  endfunction

  function automatic logic event_match(logic [1:0] s, logic a, logic b, logic c);
    case (s)
      2'b01:   return a;
      2'b10:   return b;
      2'b11:   return c;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_step();
    logic [13:0] p;
    logic off;
    p = preset_of(m_hi, m_lo);
    off = (m_hi[7:6] == 2'b00) || (p == '0);
    m_pulse = off && tx_cmd;
    if (wr_en) begin
      m_run = 1'b0;
      if (wr_addr) m_lo = wr_data; else m_hi = wr_data;
    end else if (!off && event_match(m_hi[7:6], ev_rx_start, ev_rx_end, ev_tx_end)) begin
      m_run = 1'b1;
      m_cnt = p;
    end else if (m_run && tick) begin
      if (m_cnt == 14'd1) begin
        m_run = 1'b0;
        m_pulse = 1'b1;
      end else m_cnt = m_cnt - 14'd1;
    end
  endtask

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag, tx_start, m_pulse, "tx_start");
    check(tag, busy, m_run, "busy");
  endtask

  task automatic idle();
    tick = 0; wr_en = 0; ev_rx_start = 0; ev_rx_end = 0; ev_tx_end = 0; tx_cmd = 0;
  endtask

  task automatic wr(logic a, logic [7:0] d, string tag);
    idle(); wr_en = 1; wr_addr = a; wr_data = d;
    cyc(tag);
    idle();
  endtask

  task automatic run(int n, int period, string tag);
    for (int i = 0; i < n; i++) begin
      tick = (i % period == period - 1);
      cyc(tag);
    end
    idle();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", tx_start, 1'b0, "tx_start after reset");
    check("R1", busy, 1'b0, "busy after reset");

    // R4: timer off after reset, command passes through, events ignored
    tx_cmd = 1; cyc("R4"); idle();
    ev_rx_start = 1; ev_rx_end = 1; ev_tx_end = 1; cyc("R4"); idle();

    // R2/R6: select rx_start, preset 3, ticks every cycle
    wr(1'b0, 8'h40, "R2"); wr(1'b1, 8'h03, "R2");
    ev_rx_start = 1; tick = 1; cyc("R6"); idle();
    run(5, 1, "R6");

    // R3: non-selected events ignored
    ev_rx_end = 1; ev_tx_end = 1; cyc("R3"); idle();
    check("R3", busy, 1'b0, "busy on wrong event");

    // R5: command ignored in timer mode
    tx_cmd = 1; cyc("R5"); idle();
    check("R5", tx_start, 1'b0, "tx_start on cmd in timer mode");

    // R6 exact latency: rx_end, preset 5, tick every 2 cycles
    wr(1'b0, 8'h80, "R2"); wr(1'b1, 8'h05, "R2");
    ev_rx_end = 1; cyc("R6"); idle();
    lat = 0;
    for (int i = 0; i < 20 && lat == 0; i++) begin
      tick = (i % 2 == 1);
      cyc("R6");
      if (tx_start) lat = i + 1;
    end
    idle();
    check("R6", (lat == 10), 1'b1, "latency is 10 cycles");
    cyc("R9");
    check("R9", tx_start, 1'b0, "pulse one cycle wide");

    // R7: retrigger restarts
    wr(1'b0, 8'hC0, "R2"); wr(1'b1, 8'h04, "R2");
    ev_tx_end = 1; cyc("R7"); idle();
    run(3, 1, "R7");
    ev_tx_end = 1; tick = 1; cyc("R7"); idle();
    run(3, 1, "R7");
    check("R7", busy, 1'b1, "still busy after restart");
    run(3, 1, "R7");

    // R8: write aborts, event with write ignored
    ev_tx_end = 1; cyc("R8"); idle();
    run(2, 1, "R8");
    wr_en = 1; wr_addr = 1; wr_data = 8'h04; ev_tx_end = 1; cyc("R8"); idle();
    check("R8", busy, 1'b0, "busy after write");
    run(8, 1, "R8");

    // R2: upper preset bits, preset 256
    wr(1'b0, 8'h41, "R2"); wr(1'b1, 8'h00, "R2");
    ev_rx_start = 1; cyc("R2"); idle();
    run(260, 1, "R2");

    // R4: zero preset behaves as off
    wr(1'b0, 8'h40, "R4"); wr(1'b1, 8'h00, "R4");
    ev_rx_start = 1; cyc("R4"); idle();
    check("R4", busy, 1'b0, "busy with zero preset");
    tx_cmd = 1; cyc("R4"); idle();
    check("R4", tx_start, 1'b1, "cmd passes with zero preset");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      tick        = ($urandom % 4) == 0;
      ev_rx_start = ($urandom % 12) == 0;
      ev_rx_end   = ($urandom % 12) == 0;
      ev_tx_end   = ($urandom % 12) == 0;
      tx_cmd      = ($urandom % 24) == 0;
      wr_en       = ($urandom % 80) == 0;
      wr_addr     = 1'($urandom % 2);
      if (wr_addr) wr_data = 8'($urandom % 10);
      else wr_data = {2'($urandom % 4), (($urandom % 10) == 0) ? 6'd1 : 6'd0};
      cyc("R9 random");
    end
    idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule